// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home agent for a set of memory blocks in a distributed shared-memory machine with a few nodes. Caches never broadcast their misses. Each miss travels to the home of the block as a request message, and this controller decides how to serve it. For each block it keeps three things: a coherence state (Uncached, Shared or Exclusive), one presence bit per node and the node number of the exclusive owner. Block contents sit in a small register array inside the block.

Requests are taken strictly one at a time, in the order they are offered. A read that finds the block unowned is answered from memory. A write to a block with other sharers first sends an invalidation to each of those sharers. It grants permission only after every acknowledgement has come back. When a block is exclusively owned by another node, the request is forwarded to that owner, and the owner supplies the data to the requester directly. The owner's reply message then closes the transaction. An owner can also give a block back to memory with a writeback request.

Top module: `dhc_home_ctrl`

## Requirements
- R1: After reset, req_ready is 1, msg_valid is 0, every block is Uncached with no presence bits, and block a holds the word 16'hA000 + a.
- R2: A read miss (req_kind 0) to a block that is not Exclusive under another node produces one message of kind 0 (data) to the requester, carrying the memory word. The block becomes Shared with the requester's presence bit added.
- R3: A write miss (req_kind 1) to a Shared block sends one message of kind 1 (invalidate) to each other node whose presence bit is set, in increasing node order. No invalidate goes to the requester.
- R4: A data grant for a write follows only after one acknowledgement (ack_kind 0) has been accepted for every invalidate sent. An acknowledgement may be accepted in the same cycle as an invalidate is issued.
- R5: A write miss to an Uncached block, or to a Shared block with no other sharer, is answered at once with a data message carrying the memory word. The writer becomes the Exclusive owner and the only sharer.
- R6: A write miss to a block held Exclusive by another node sends a message of kind 3 (forward-write) to the owner, with msg_req naming the requester. After the owner's reply (ack_kind 1), the requester is the owner.
- R7: A read miss to a block held Exclusive by another node sends a message of kind 2 (forward-read) to the owner, with msg_req naming the requester. The owner's reply data is written to memory, and the block becomes Shared by owner and requester.
- R8: req_ready is low from the acceptance of a read or write miss until its transaction completes. Requests are therefore served one at a time, in acceptance order.
- R9: A writeback (req_kind 2) from the Exclusive owner stores req_data in memory and makes the block Uncached with all presence bits cleared.
- R10: A writeback from a node that is not the Exclusive owner has no effect on memory or on the directory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_src | input | NW | Requesting node |
| req_addr | input | AW | Block index |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_data | input | DATA_W | Writeback data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Network takes the message |
| msg_dst | output | NW | Destination node |
| msg_kind | output | 2 | 0 data, 1 invalidate, 2 forward-read, 3 forward-write |
| msg_addr | output | AW | Block index of the message |
| msg_req | output | NW | Original requester (for forwards) |
| msg_data | output | DATA_W | Block word for data messages, else 0 |
| ack_valid | input | 1 | Acknowledgement or owner reply offered |
| ack_ready | output | 1 | Controller takes acknowledgements |
| ack_src | input | NW | Sending node |
| ack_kind | input | 1 | 0 invalidate ack, 1 owner reply with data |
| ack_data | input | DATA_W | Owner data |

## Verification
Issuing an invalidate and counting an acknowledgement can both happen in the same clock. The grant check relies on the two running counts staying consistent in that case. The bench provokes this by raising each sharer's acknowledgement in the very cycle its invalidate is handed to the network. It then requires exactly one data grant to the writer, once the last pair completes. A second scenario holds the acknowledgements back and checks that no grant shows up while any of them is still missing.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    typedef enum logic [1:0] {
        BLK_UNC = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_DATA   = 2'd0,
        MS_INV    = 2'd1,
        MS_FWD_RD = 2'd2,
        MS_FWD_WR = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_REPLY,
        CS_INV,
        CS_FWD,
        CS_WOWN
    } ctl_state_e;

    localparam logic ACK_INV   = 1'b0;
    localparam logic ACK_OWNER = 1'b1;

    function automatic logic [31:0] seed_word(input int unsigned idx);
        return 32'hA000 + idx;
    endfunction

endpackage

// File: rtl/dhc_dir_store.sv
module dhc_dir_store
    import dhc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     rd_addr,
    output blk_state_e        rd_state,
    output logic [NODES-1:0]  rd_pres,
    output logic [NW-1:0]     rd_owner,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  blk_state_e        wr_state,
    input  logic [NODES-1:0]  wr_pres,
    input  logic [NW-1:0]     wr_owner,
    input  logic              mem_we,
    input  logic [AW-1:0]     mem_addr,
    input  logic [DATA_W-1:0] mem_wdata
);
    blk_state_e        st_q  [BLOCKS];
    logic [NODES-1:0]  pr_q  [BLOCKS];
    logic [NW-1:0]     ow_q  [BLOCKS];
    logic [DATA_W-1:0] wd_q  [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[b] <= BLK_UNC;
                pr_q[b] <= '0;
                ow_q[b] <= '0;
                wd_q[b] <= DATA_W'(seed_word(b));
            end else begin
                if (wr_en && wr_addr == AW'(b)) begin
                    st_q[b] <= wr_state;
                    pr_q[b] <= wr_pres;
                    ow_q[b] <= wr_owner;
                end
                if (mem_we && mem_addr == AW'(b)) begin
                    wd_q[b] <= mem_wdata;
                end
            end
        end
    end

    assign rd_state = st_q[rd_addr];
    assign rd_pres  = pr_q[rd_addr];
    assign rd_owner = ow_q[rd_addr];
    assign rd_data  = wd_q[rd_addr];

endmodule

// File: rtl/dhc_inv_track.sv
module dhc_inv_track #(
    parameter int NODES = 4,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int CW = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NODES-1:0] load_vec,
    input  logic             send_fire,
    input  logic             ack_fire,
    output logic [NW-1:0]    cur_dst,
    output logic             pending_any,
    output logic             done
);
    logic [NODES-1:0] pend_q;
    logic [CW-1:0]    need_q;
    logic [CW-1:0]    got_q;

    always_comb begin
        cur_dst = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (pend_q[i]) cur_dst = NW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            need_q <= '0;
            got_q  <= '0;
        end else if (load) begin
            pend_q <= load_vec;
            need_q <= CW'($countones(load_vec));
            got_q  <= '0;
        end else begin
            if (send_fire) pend_q[cur_dst] <= 1'b0;
            if (ack_fire)  got_q <= got_q + CW'(1);
        end
    end

    assign pending_any = |pend_q;
    assign done        = (pend_q == '0) && (got_q == need_q);

endmodule

// File: rtl/dhc_home_ctrl.sv
module dhc_home_ctrl
    import dhc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NW-1:0]     req_src,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [NW-1:0]     msg_dst,
    output logic [1:0]        msg_kind,
    output logic [AW-1:0]     msg_addr,
    output logic [NW-1:0]     msg_req,
    output logic [DATA_W-1:0] msg_data,
    input  logic              ack_valid,
    output logic              ack_ready,
    input  logic [NW-1:0]     ack_src,
    input  logic              ack_kind,
    input  logic [DATA_W-1:0] ack_data
);
    ctl_state_e state_q;
    req_kind_e  t_kind_q;
    logic [NW-1:0] t_src_q, t_owner_q;
    logic [AW-1:0] t_addr_q;

    logic [AW-1:0]     rd_addr;
    blk_state_e        rd_state;
    logic [NODES-1:0]  rd_pres;
    logic [NW-1:0]     rd_owner;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en, mem_we;
    logic [AW-1:0]     wr_addr;
    blk_state_e        wr_state;
    logic [NODES-1:0]  wr_pres;
    logic [NW-1:0]     wr_owner;
    logic [DATA_W-1:0] mem_wdata;

    logic [NW-1:0]    inv_dst;
    logic             inv_pending, inv_done, inv_load;
    logic [NODES-1:0] req_bit, t_bit, own_bit, others;

    req_kind_e in_kind;
    logic      accept, msg_fire, ack_fire, owned_elsewhere;

    assign in_kind  = req_kind_e'(req_kind);
    assign req_ready = (state_q == CS_IDLE);
    assign ack_ready = (state_q == CS_INV) || (state_q == CS_WOWN);
    assign accept    = req_valid && req_ready;
    assign msg_fire  = msg_valid && msg_ready;
    assign ack_fire  = ack_valid && ack_ready;

    assign rd_addr  = (state_q == CS_IDLE) ? req_addr : t_addr_q;
    assign req_bit  = NODES'(1) << req_src;
    assign t_bit    = NODES'(1) << t_src_q;
    assign own_bit  = NODES'(1) << t_owner_q;
    assign others   = rd_pres & ~req_bit;
    assign owned_elsewhere = (rd_state == BLK_EXC) && (rd_owner != req_src);
    assign inv_load = accept && in_kind == RQ_WRITE && !owned_elsewhere
                      && rd_state == BLK_SHR && others != '0;

    dhc_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_store (
        .clk, .rst, .rd_addr, .rd_state, .rd_pres, .rd_owner, .rd_data,
        .wr_en, .wr_addr, .wr_state, .wr_pres, .wr_owner,
        .mem_we, .mem_addr(wr_addr), .mem_wdata
    );

    dhc_inv_track #(.NODES(NODES)) i_track (
        .clk, .rst,
        .load(inv_load), .load_vec(others),
        .send_fire(state_q == CS_INV && msg_fire),
        .ack_fire(state_q == CS_INV && ack_fire && ack_kind == ACK_INV),
        .cur_dst(inv_dst), .pending_any(inv_pending), .done(inv_done)
    );

    // outgoing message
    always_comb begin
        msg_valid = 1'b0;
        msg_dst   = t_src_q;
        msg_kind  = MS_DATA;
        msg_data  = '0;
        unique case (state_q)
            CS_REPLY: begin
                msg_valid = 1'b1;
                msg_data  = rd_data;
            end
            CS_INV: begin
                msg_valid = inv_pending;
                msg_dst   = inv_dst;
                msg_kind  = MS_INV;
            end
            CS_FWD: begin
                msg_valid = 1'b1;
                msg_dst   = t_owner_q;
                msg_kind  = (t_kind_q == RQ_READ) ? MS_FWD_RD : MS_FWD_WR;
            end
            default: ;
        endcase
    end
    assign msg_addr = t_addr_q;
    assign msg_req  = t_src_q;

    // directory and memory updates
    always_comb begin
        wr_en     = 1'b0;
        mem_we    = 1'b0;
        wr_addr   = t_addr_q;
        wr_state  = BLK_UNC;
        wr_pres   = '0;
        wr_owner  = t_src_q;
        mem_wdata = ack_data;
        if (accept && in_kind == RQ_WBACK) begin
            wr_addr   = req_addr;
            mem_wdata = req_data;
            if (rd_state == BLK_EXC && rd_owner == req_src) begin
                wr_en  = 1'b1;
                mem_we = 1'b1;
                wr_owner = req_src;
            end
        end else if (state_q == CS_REPLY && msg_fire) begin
            wr_en = 1'b1;
            if (t_kind_q == RQ_READ) begin
                wr_state = BLK_SHR;
                wr_pres  = rd_pres | t_bit;
                wr_owner = rd_owner;
            end else begin
                wr_state = BLK_EXC;
                wr_pres  = t_bit;
            end
        end else if (state_q == CS_WOWN && ack_fire && ack_kind == ACK_OWNER
                     && ack_src == t_owner_q) begin
            wr_en = 1'b1;
            if (t_kind_q == RQ_READ) begin
                mem_we   = 1'b1;
                wr_state = BLK_SHR;
                wr_pres  = t_bit | own_bit;
                wr_owner = t_owner_q;
            end else begin
                wr_state = BLK_EXC;
                wr_pres  = t_bit;
            end
        end
    end

    // transaction sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CS_IDLE;
            t_kind_q  <= RQ_READ;
            t_src_q   <= '0;
            t_owner_q <= '0;
            t_addr_q  <= '0;
        end else begin
            unique case (state_q)
                CS_IDLE: if (accept && in_kind != RQ_WBACK) begin
                    t_kind_q  <= in_kind;
                    t_src_q   <= req_src;
                    t_addr_q  <= req_addr;
                    t_owner_q <= rd_owner;
                    if (owned_elsewhere)  state_q <= CS_FWD;
                    else if (inv_load)    state_q <= CS_INV;
                    else                  state_q <= CS_REPLY;
                end
                CS_REPLY: if (msg_fire) state_q <= CS_IDLE;
                CS_INV:   if (inv_done) state_q <= CS_REPLY;
                CS_FWD:   if (msg_fire) state_q <= CS_WOWN;
                CS_WOWN:  if (ack_fire && ack_kind == ACK_OWNER && ack_src == t_owner_q)
                              state_q <= CS_IDLE;
                default:  state_q <= CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dhc_home_chk.sv
module dhc_home_chk
    import dhc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16,
    localparam int AW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int NW = (NODES > 1) ? $clog2(NODES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [NW-1:0]     req_src,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [NW-1:0]     msg_dst,
    input logic [1:0]        msg_kind,
    input logic [NW-1:0]     msg_req,
    input logic              ack_valid,
    input logic              ack_ready,
    input logic              ack_kind
);
    logic [NW-1:0] last_src;
    logic [7:0]    inv_sent, inv_acked;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_src  <= '0;
            inv_sent  <= '0;
            inv_acked <= '0;
        end else if (req_valid && req_ready) begin
            last_src  <= req_src;
            inv_sent  <= '0;
            inv_acked <= '0;
        end else begin
            if (msg_valid && msg_ready && msg_kind == MS_INV) inv_sent <= inv_sent + 8'd1;
            if (ack_valid && ack_ready && ack_kind == ACK_INV) inv_acked <= inv_acked + 8'd1;
        end
    end

    // R8
    busy_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !req_ready);

    // R8
    ack_in_txn_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_ready) |-> !req_ready);

    // R4
    grant_after_acks_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_DATA) |-> (inv_sent == inv_acked));

    // R3
    inv_skips_writer_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INV) |-> (msg_dst != last_src));

    // R6
    fwd_names_req_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && (msg_kind == MS_FWD_RD || msg_kind == MS_FWD_WR)) |-> (msg_req == last_src));

    // R3
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dst) && $stable(msg_kind)));

endmodule

bind dhc_home_ctrl dhc_home_chk #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dst(msg_dst), .msg_kind(msg_kind),
    .msg_req(msg_req), .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_kind(ack_kind)
);

// File: tb/test_dhc_home_ctrl.sv
module test_dhc_home_ctrl;
    localparam int NODES = 4, BLOCKS = 8, DATA_W = 16;
    localparam int AW = 3, NW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_ready;
    logic [NW-1:0] req_src = 0;
    logic [AW-1:0] req_addr = 0;
    logic [1:0] req_kind = 0;
    logic [DATA_W-1:0] req_data = 0;
    logic msg_valid, msg_ready = 0;
    logic [NW-1:0] msg_dst, msg_req;
    logic [1:0] msg_kind;
    logic [AW-1:0] msg_addr;
    logic [DATA_W-1:0] msg_data;
    logic ack_valid = 0, ack_ready;
    logic [NW-1:0] ack_src = 0;
    logic ack_kind = 0;
    logic [DATA_W-1:0] ack_data = 0;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    dhc_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) i_dhc_home_ctrl (
        .clk, .rst, .req_valid, .req_ready, .req_src, .req_addr, .req_kind, .req_data,
        .msg_valid, .msg_ready, .msg_dst, .msg_kind, .msg_addr, .msg_req, .msg_data,
        .ack_valid, .ack_ready, .ack_src, .ack_kind, .ack_data
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_req(input int src, input int addr, input int kind, input int data);
        @(negedge clk);
        req_valid = 1; req_src = NW'(src); req_addr = AW'(addr);
        req_kind = 2'(kind); req_data = DATA_W'(data);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic send_ack(input int src, input int kind, input int data);
        @(negedge clk);
        ack_valid = 1; ack_src = NW'(src); ack_kind = kind[0]; ack_data = DATA_W'(data);
        while (!ack_ready) @(negedge clk);
        @(posedge clk); #1;
        ack_valid = 0;
    endtask

    // waits for a message; optionally acknowledges an invalidate in the same cycle
    task automatic get_msg(input int dst, input int kind, input int payload,
                           input bit same_ack, input string tag);
        int waited = 0;
        @(negedge clk);
        msg_ready = 1;
        while (!msg_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        chk(msg_valid, {tag, " msg present"}, 32'(msg_valid), 32'd1);
        chk(msg_dst == NW'(dst) && msg_kind == 2'(kind), {tag, " dst/kind"},
            {28'd0, msg_dst, msg_kind}, 32'((dst << 2) | kind));
        if (kind == 0)
            chk(msg_data == DATA_W'(payload), {tag, " data"}, 32'(msg_data), 32'(payload));
        if (kind >= 2)
            chk(msg_req == NW'(payload), {tag, " requester"}, 32'(msg_req), 32'(payload));
        if (same_ack) begin
            ack_valid = 1; ack_src = msg_dst; ack_kind = 0;
        end
        @(posedge clk); #1;
        msg_ready = 0;
        ack_valid = 0;
    endtask

    task automatic quiet(input int cycles, input string tag);
        bit seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        chk(!seen, tag, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(msg_valid == 1'b0, "R1 no message after reset", 32'(msg_valid), 32'd0);
    endtask

    task automatic t_read_shared;
        send_req(1, 2, 0, 0);
        get_msg(1, 0, 16'hA002, 0, "R1 R2 first read");
        send_req(3, 2, 0, 0);
        get_msg(3, 0, 16'hA002, 0, "R2 second reader");
    endtask

    task automatic t_write_held_acks;
        send_req(0, 2, 1, 0);
        get_msg(1, 1, 0, 0, "R3 inv node1 first");
        get_msg(3, 1, 0, 0, "R3 inv node3 second");
        quiet(6, "R4 no grant while acks missing");
        send_ack(3, 0, 0);
        quiet(3, "R4 no grant with one ack missing");
        send_ack(1, 0, 0);
        get_msg(0, 0, 16'hA002, 0, "R4 grant after acks");
    endtask

    task automatic t_forwards;
        send_req(2, 2, 1, 0);
        get_msg(0, 3, 2, 0, "R6 forward-write to owner");
        @(negedge clk);
        chk(req_ready == 1'b0, "R8 busy while owner pending", 32'(req_ready), 32'd0);
        send_ack(0, 1, 16'h1234);
        send_req(1, 2, 0, 0);
        get_msg(2, 2, 1, 0, "R6 R7 forward-read to new owner");
        send_ack(2, 1, 16'h5555);
        send_req(3, 2, 0, 0);
        get_msg(3, 0, 16'h5555, 0, "R7 memory updated by owner data");
    endtask

    task automatic t_write_same_cycle_acks;
        send_req(1, 2, 1, 0);
        get_msg(2, 1, 0, 1, "R3 R4 inv node2 with ack");
        get_msg(3, 1, 0, 1, "R3 R4 inv node3 with ack");
        get_msg(1, 0, 16'h5555, 0, "R4 grant after same-cycle acks");
    endtask

    task automatic t_writebacks;
        send_req(0, 2, 2, 16'hDEAD);
        quiet(2, "R10 stray writeback sends nothing");
        send_req(1, 2, 2, 16'hBEEF);
        send_req(3, 2, 1, 0);
        get_msg(3, 0, 16'hBEEF, 0, "R9 R10 write after writeback");
    endtask

    task automatic t_write_uncached;
        send_req(2, 5, 1, 0);
        get_msg(2, 0, 16'hA005, 0, "R5 grant on uncached block");
        send_req(0, 5, 0, 0);
        get_msg(2, 2, 0, 0, "R5 writer became owner");
        send_ack(2, 1, 16'h0777);
        send_req(2, 6, 0, 0);
        get_msg(2, 0, 16'hA006, 0, "R2 read of untouched block");
        send_req(2, 6, 1, 0);
        get_msg(2, 0, 16'hA006, 0, "R5 sole sharer upgrade");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_read_shared();
        t_write_held_acks();
        t_forwards();
        t_write_same_cycle_acks();
        t_writebacks();
        t_write_uncached();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule